// File: doc/BRIEF.md
# Streaming Pixel Operability Classifier

This block sorts the pixels of an infrared detector frame into operable and inoperable ones while calibrated per-pixel values stream past in raster order. Each beat carries a signed dark-generation rate, efficiency figures for the J, H and K bands, and a connectivity delta. The delta is the difference between two frames taken at different detector common voltages. A pixel that is properly bonded to its diode shifts with that voltage; an unconnected pixel does not. The block compares each value against programmable limits and emits a defect code that holds one cause bit per test.

The results form a defect bitmap in raster order. Two saturating counters run alongside: one for inoperable pixels and one for open pixels. Both restart on the first pixel of each frame. Reference pixels also show no shift with the common voltage, so a per-pixel reference flag keeps them from being reported as open.

The input and output are valid/ready streams. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. The result register therefore forms a single-entry pipeline. A pixel accepted at a clock edge has its result on the `m_*` pins after that edge. While `m_valid` is high and `m_ready` is low, the result and the counts are held and no new pixel is accepted. The configuration pins are sampled at the moment a pixel is accepted.

Top module: `pix_oper_classifier`

## Requirements
- R1: `s_ready` equals `!m_valid || m_ready`. A pixel accepted at a clock edge appears on the output (`m_valid` high) from that edge on. The output code and the counts stay unchanged while `m_valid` is high and `m_ready` is low.
- R2: Code bit 0 (dark high) is set when the signed dark rate is strictly greater than the signed `cfg_dark_max`. A rate equal to the limit does not set it.
- R3: Code bit 1 (dark negative) is set when the signed dark rate is below zero. A rate of zero does not set it.
- R4: Code bits 2, 3 and 4 flag the J, H and K bands. Each bit is set when that band's efficiency is strictly below its own minimum (`cfg_qe_min_j`, `_h`, `_k`). Equality passes.
- R5: Code bit 5 (open) is set when the absolute connectivity delta is at or below `cfg_open_tol` and the reference flag is low. A pixel with the reference flag high never has bit 5 set.
- R6: `m_inop` is the OR of code bits 0 to 4. The open bit alone does not make a pixel inoperable.
- R7: `m_inop_cnt` restarts on each accepted start-of-frame pixel, counting that pixel. It then adds one per accepted inoperable pixel, and its value on the output includes the pixel shown. It saturates at all ones.
- R8: `m_open_cnt` follows the same rules for pixels with code bit 5 set. It saturates at all ones.
- R9: The start-of-frame and end-of-frame markers travel with their pixel to `m_sof` and `m_eof`.
- R10: Both counts keep their value in every cycle in which no pixel is accepted, so the totals remain readable after the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can accept a pixel |
| s_sof | input | 1 | First pixel of a frame |
| s_eof | input | 1 | Last pixel of a frame |
| s_ref | input | 1 | Reference pixel, masks the open test |
| s_dark | input | DARK_W | Signed dark-generation rate |
| s_qe_j | input | QE_W | J-band efficiency |
| s_qe_h | input | QE_W | H-band efficiency |
| s_qe_k | input | QE_W | K-band efficiency |
| s_conn | input | CONN_W | Signed connectivity delta |
| cfg_dark_max | input | DARK_W | Signed upper dark limit |
| cfg_qe_min_j | input | QE_W | J-band minimum efficiency |
| cfg_qe_min_h | input | QE_W | H-band minimum efficiency |
| cfg_qe_min_k | input | QE_W | K-band minimum efficiency |
| cfg_open_tol | input | CONN_W | Unsigned tolerance for the open test |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Consumer takes the result |
| m_sof | output | 1 | Result is first of frame |
| m_eof | output | 1 | Result is last of frame |
| m_code | output | 6 | Defect cause bits |
| m_inop | output | 1 | Pixel inoperable |
| m_inop_cnt | output | CNT_W | Saturating inoperable count |
| m_open_cnt | output | CNT_W | Saturating open count |

## Verification
The hardest case to reach is counter saturation at the same time as back-pressure. The counter must sit at all ones and stay frozen while results stall, and then restart cleanly on the next start-of-frame. The bench builds the block with a 4-bit counter width so that a frame of twenty defective, open pixels drives both counts past their ceiling. It toggles `m_ready` pseudo-randomly during that frame so that stalls occur at the saturated value. A short frame follows and must show the counts restarting from zero.

// File: rtl/pix_oper_pkg.sv
package pix_oper_pkg;
  localparam int CODE_W     = 6;
  localparam int BIT_DARK_HI = 0;
  localparam int BIT_DARK_NEG = 1;
  localparam int BIT_QE_J   = 2;
  localparam int BIT_QE_H   = 3;
  localparam int BIT_QE_K   = 4;
  localparam int BIT_OPEN   = 5;
  localparam int N_BANDS    = 3;
endpackage

// File: rtl/pix_dark_check.sv
module pix_dark_check #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] rate,
  input  logic signed [W-1:0] limit,
  output logic                too_high,
  output logic                negative
);
  always_comb begin
    too_high = rate > limit;
    negative = rate[W-1];
  end
endmodule

// File: rtl/pix_qe_check.sv
module pix_qe_check #(
  parameter int W = 10
) (
  input  logic [W-1:0] eff,
  input  logic [W-1:0] floor_val,
  output logic         below
);
  always_comb below = eff < floor_val;
endmodule

// File: rtl/pix_open_check.sv
module pix_open_check #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] delta,
  input  logic        [W-1:0] tol,
  input  logic                is_ref,
  output logic                open
);
  localparam int AW = W + 1;
  logic [AW-1:0] mag;
  always_comb begin
    if (delta[W-1]) mag = AW'(-$signed({delta[W-1], delta}));
    else            mag = AW'({1'b0, delta});
    open = !is_ref && (mag <= {1'b0, tol});
  end
endmodule

// File: rtl/pix_sat_count.sv
module pix_sat_count #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] base;
  always_comb base = clr ? '0 : cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (en) begin
      if (inc && base != TOP) cnt <= base + 1'b1;
      else                    cnt <= base;
    end
  end
endmodule

// File: rtl/pix_oper_classifier.sv
module pix_oper_classifier
  import pix_oper_pkg::*;
#(
  parameter int DARK_W = 16,
  parameter int QE_W   = 10,
  parameter int CONN_W = 16,
  parameter int CNT_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic                     s_sof,
  input  logic                     s_eof,
  input  logic                     s_ref,
  input  logic signed [DARK_W-1:0] s_dark,
  input  logic        [QE_W-1:0]   s_qe_j,
  input  logic        [QE_W-1:0]   s_qe_h,
  input  logic        [QE_W-1:0]   s_qe_k,
  input  logic signed [CONN_W-1:0] s_conn,
  input  logic signed [DARK_W-1:0] cfg_dark_max,
  input  logic        [QE_W-1:0]   cfg_qe_min_j,
  input  logic        [QE_W-1:0]   cfg_qe_min_h,
  input  logic        [QE_W-1:0]   cfg_qe_min_k,
  input  logic        [CONN_W-1:0] cfg_open_tol,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     m_sof,
  output logic                     m_eof,
  output logic [CODE_W-1:0]        m_code,
  output logic                     m_inop,
  output logic [CNT_W-1:0]         m_inop_cnt,
  output logic [CNT_W-1:0]         m_open_cnt
);
  logic              accept;
  logic [CODE_W-1:0] code_d;
  logic              inop_d;
  logic [QE_W-1:0]   band_eff [N_BANDS];
  logic [QE_W-1:0]   band_min [N_BANDS];
  logic [N_BANDS-1:0] band_low;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  always_comb begin
    band_eff[0] = s_qe_j;       band_min[0] = cfg_qe_min_j;
    band_eff[1] = s_qe_h;       band_min[1] = cfg_qe_min_h;
    band_eff[2] = s_qe_k;       band_min[2] = cfg_qe_min_k;
  end

  pix_dark_check #(.W(DARK_W)) u_dark (
    .rate(s_dark), .limit(cfg_dark_max),
    .too_high(code_d[BIT_DARK_HI]), .negative(code_d[BIT_DARK_NEG])
  );

  for (genvar b = 0; b < N_BANDS; b++) begin : g_band
    pix_qe_check #(.W(QE_W)) u_qe (
      .eff(band_eff[b]), .floor_val(band_min[b]), .below(band_low[b])
    );
  end
  assign code_d[BIT_QE_K:BIT_QE_J] = band_low;

  pix_open_check #(.W(CONN_W)) u_open (
    .delta(s_conn), .tol(cfg_open_tol), .is_ref(s_ref), .open(code_d[BIT_OPEN])
  );

  assign inop_d = |code_d[BIT_QE_K:BIT_DARK_HI];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_sof   <= 1'b0;
      m_eof   <= 1'b0;
      m_code  <= '0;
      m_inop  <= 1'b0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_sof   <= s_sof;
      m_eof   <= s_eof;
      m_code  <= code_d;
      m_inop  <= inop_d;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  pix_sat_count #(.W(CNT_W)) u_inop_cnt (
    .clk(clk), .rst_n(rst_n), .en(accept), .clr(s_sof), .inc(inop_d), .cnt(m_inop_cnt)
  );
  pix_sat_count #(.W(CNT_W)) u_open_cnt (
    .clk(clk), .rst_n(rst_n), .en(accept), .clr(s_sof), .inc(code_d[BIT_OPEN]), .cnt(m_open_cnt)
  );
endmodule

// File: rtl/pix_oper_classifier_chk.sv
module pix_oper_classifier_chk
  import pix_oper_pkg::*;
#(
  parameter int DARK_W = 16,
  parameter int CNT_W  = 23
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     s_valid,
  input logic                     s_ready,
  input logic                     s_sof,
  input logic signed [DARK_W-1:0] cfg_dark_max,
  input logic                     m_valid,
  input logic                     m_ready,
  input logic [CODE_W-1:0]        m_code,
  input logic [CNT_W-1:0]         m_inop_cnt,
  input logic [CNT_W-1:0]         m_open_cnt
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_code) && $stable(m_inop_cnt));

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);

  // R2 and R3 cannot both fire while the upper dark limit is non-negative
  p_dark_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !cfg_dark_max[DARK_W-1] |-> !(m_code[BIT_DARK_HI] && m_code[BIT_DARK_NEG]));

  p_sof_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_sof |=> m_inop_cnt <= CNT_W'(1) && m_open_cnt <= CNT_W'(1));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !s_sof |=>
      (m_open_cnt == $past(m_open_cnt)) || (m_open_cnt == CNT_W'($past(m_open_cnt) + 1'b1)));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(m_inop_cnt) && $stable(m_open_cnt));
endmodule

bind pix_oper_classifier pix_oper_classifier_chk #(.DARK_W(DARK_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pix_oper_classifier_tb.sv
module pix_oper_classifier_tb;
  localparam int CW = 4;
  localparam int SAT = 15;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_sof = 0, s_eof = 0, s_ref = 0, m_ready = 1;
  logic signed [15:0] s_dark = 0, s_conn = 0, cfg_dark_max;
  logic [9:0] s_qe_j = 0, s_qe_h = 0, s_qe_k = 0, cfg_qe_min_j, cfg_qe_min_h, cfg_qe_min_k;
  logic [15:0] cfg_open_tol;
  logic s_ready, m_valid, m_sof, m_eof, m_inop;
  logic [5:0] m_code;
  logic [CW-1:0] m_inop_cnt, m_open_cnt;

  int c_dmax = 8, c_j = 380, c_h = 470, c_k = 470, c_tol = 3;
  assign cfg_dark_max = 16'(c_dmax);
  assign cfg_qe_min_j = 10'(c_j);
  assign cfg_qe_min_h = 10'(c_h);
  assign cfg_qe_min_k = 10'(c_k);
  assign cfg_open_tol = 16'(c_tol);

  always #2 clk = ~clk;

  pix_oper_classifier #(.CNT_W(CW)) u_dut (.*);

  typedef struct { logic [5:0] code; logic inop, sof, eof; int icnt, ocnt; } exp_t;
  exp_t q[$];
  int mi = 0, mo = 0, total = 0, fails = 0;
  bit bp_on = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit sof, input bit eof, input bit rf, input int dark,
                      input int qj, input int qh, input int qk, input int conn);
    exp_t e;
    int mag;
    mag = conn < 0 ? -conn : conn;
    e.code = '0;
    e.code[0] = dark > c_dmax;
    e.code[1] = dark < 0;
    e.code[2] = qj < c_j;
    e.code[3] = qh < c_h;
    e.code[4] = qk < c_k;
    e.code[5] = !rf && mag <= c_tol;
    e.inop = |e.code[4:0];
    e.sof = sof; e.eof = eof;
    if (sof) begin mi = 0; mo = 0; end
    if (e.inop && mi < SAT) mi++;
    if (e.code[5] && mo < SAT) mo++;
    e.icnt = mi; e.ocnt = mo;
    @(negedge clk);
    s_valid = 1; s_sof = sof; s_eof = eof; s_ref = rf;
    s_dark = 16'(dark); s_qe_j = 10'(qj); s_qe_h = 10'(qh); s_qe_k = 10'(qk); s_conn = 16'(conn);
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk); s_valid = 0;
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    bit held = 0;
    logic [5:0] hcode;
    int hcnt;
    wait (rst_n);
    forever begin
      @(negedge clk);
      m_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
      #2;
      if (held) chk(m_valid && m_code == hcode && int'(m_inop_cnt) == hcnt,
                    "R1 output held under back-pressure", int'(m_code), int'(hcode));
      held = m_valid && !m_ready;
      hcode = m_code; hcnt = int'(m_inop_cnt);
      if (m_valid && m_ready) begin
        if (q.size() == 0) chk(0, "R1 unexpected output", 1, 0);
        else begin
          e = q.pop_front();
          chk(m_code == e.code, "R2 R3 R4 R5 defect code", int'(m_code), int'(e.code));
          chk(m_inop == e.inop, "R6 inoperable flag", int'(m_inop), int'(e.inop));
          chk(m_sof == e.sof && m_eof == e.eof, "R9 frame markers",
              int'({m_sof, m_eof}), int'({e.sof, e.eof}));
          chk(int'(m_inop_cnt) == e.icnt, "R7 inoperable count", int'(m_inop_cnt), e.icnt);
          chk(int'(m_open_cnt) == e.ocnt, "R8 open count", int'(m_open_cnt), e.ocnt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!m_valid && m_inop_cnt == 0 && m_open_cnt == 0, "R1 reset state", int'(m_valid), 0);
    chk(s_ready, "R1 ready after reset", int'(s_ready), 1);

    // frame 1: edge cases of every test
    send(1, 0, 0,  3, 500, 500, 500, 100);   // good
    send(0, 0, 0,  9, 500, 500, 500, 100);   // R2 just above
    send(0, 0, 0,  8, 500, 500, 500, 100);   // R2 equal passes
    send(0, 0, 0, -1, 500, 500, 500, 100);   // R3 negative
    send(0, 0, 0,  0, 500, 500, 500, 100);   // R3 zero passes
    send(0, 0, 0,  2, 379, 500, 500, 100);   // R4 J low
    send(0, 0, 0,  2, 380, 469, 500, 100);   // R4 H low, J equal
    send(0, 0, 0,  2, 380, 470, 469, 100);   // R4 K low
    send(0, 0, 0,  2, 500, 500, 500,   3);   // R5 open at tol
    send(0, 0, 0,  2, 500, 500, 500,  -3);   // R5 open negative
    send(0, 0, 0,  2, 500, 500, 500,   4);   // R5 just connected
    send(0, 0, 1,  2, 500, 500, 500,   0);   // R5 reference masked
    send(0, 0, 0, 20, 100, 100, 100,  -4);   // several causes
    send(0, 1, 0,  2, 500, 500, 500,   1);   // open only, R6 not inop
    drain();
    chk(int'(m_inop_cnt) == mi, "R10 inoperable total held", int'(m_inop_cnt), mi);
    chk(int'(m_open_cnt) == mo, "R10 open total held", int'(m_open_cnt), mo);

    // frame 2: saturation under back-pressure
    bp_on = 1;
    for (int i = 0; i < 20; i++) send(i == 0, i == 19, 0, 100, 500, 500, 500, 0);
    drain();
    chk(int'(m_inop_cnt) == SAT, "R7 saturated", int'(m_inop_cnt), SAT);
    chk(int'(m_open_cnt) == SAT, "R8 saturated", int'(m_open_cnt), SAT);

    // frame 3: new limits, counts restart
    c_dmax = 50; c_j = 100; c_h = 100; c_k = 100; c_tol = 0;
    send(1, 0, 0, 40, 100, 100, 100, 1);
    send(0, 1, 0, 51, 99, 100, 100, 0);
    drain();
    chk(int'(m_inop_cnt) == 1, "R7 restart at frame start", int'(m_inop_cnt), 1);
    chk(int'(m_open_cnt) == 1, "R8 restart at frame start", int'(m_open_cnt), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule